// File: doc/BRIEF.md
# Multi-Lane Trapezoidal Pulse Shaper

This block shapes raw detector pulses into trapezoids. Each lane receives one signed two's-complement sample per clock from an analog-to-digital converter. The lane runs the sample through a finite-impulse-response filter whose taps are fixed when the design is built. Those taps are chosen so that the filter undoes the rising-then-decaying response of the preamplifier and then smooths the result into a flat-topped trapezoid. The impulse response is finite and there is no feedback, so every output is a plain weighted sum of the last `NTAPS` accepted samples.

All lanes share one coefficient set, but each lane keeps its own delay line and its own arithmetic. The multiply-accumulate uses no multipliers. Every bit position of the taps is handled in parallel. Each group of four taps addresses a 16-entry partial-sum table for each bit. The partial sums are weighted by bit position, with the sign bit subtracted, and then added in a short pipeline. The result is one full-precision output per clock per lane, with no rounding or saturation. A valid flag travels with the data at a fixed latency.

Top module: `trap_shaper_top`

## Requirements
- R1: While `rst_n` is low, and during the first four clocks after it rises, every `out_valid` bit is 0. Immediately after reset, every `out_data` lane reads 0.
- R2: `out_valid[c]` equals `in_valid[c]` as sampled four rising edges earlier. Every accepted sample produces exactly one valid output, and no valid output appears without one.
- R3: For lane c, data lane c occupies bits `[c*DW +: DW]` of `in_data` and bits `[c*OW +: OW]` of `out_data`, where OW = DW + CW + clog2(NTAPS). Each valid output equals the sum over k of `h[k]·x[n-k]`, where x[n] is the newest accepted sample. Both samples and coefficients are two's complement. Coefficient `h[k]` sits in bits `[k*CW +: CW]` of `COEFS`.
- R4: If a lane accepts a single nonzero sample A after all-zero history, followed by zeros, its outputs are A·h[0], A·h[1], …, A·h[NTAPS-1], and then 0.
- R5: Lanes are independent. A stimulus on one lane leaves the outputs of the other lanes at the values their own inputs give.
- R6: Full-scale inputs, both the most negative value (-2^(DW-1)) and the most positive value, give the exact convolution, with no wrap or clipping.
- R7: A sample enters the delay line only in a clock where its lane's `in_valid` is 1. Clocks without a valid input change neither the lane's history nor its next result.
- R8: A reset in the middle of a stream clears every delay line. The first outputs after reset depend only on samples accepted after reset, with zeros in place of the older history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | NCH | Per-lane sample valid |
| in_data | input | NCH*DW | Per-lane signed samples, lane c in bits [c*DW +: DW] |
| out_valid | output | NCH | Per-lane shaped-output valid |
| out_data | output | NCH*OW | Per-lane signed shaped samples, lane c in bits [c*OW +: OW] |

## Verification
The checks are arranged so that any corruption of internal state becomes visible at the ports within the latency plus the filter length. A bad partial-sum table entry, a dropped or swapped bit, or an unsigned treatment of the sign bit shows up as a wrong value at the next valid output whose taps hit that entry. A delay line that shifts when it should not, or fails to clear at reset, causes a mismatch within `NTAPS` valid outputs. Isolated impulses make each coefficient appear alone in its own cycle, so an error points to a single tap. A broken valid path appears as a flag mismatch four clocks after the input, and as items left over in, or missing from, the expected queue.

// File: rtl/trap_pkg.sv
// Shared constants for the trapezoidal shaper.
// Assumes: lanes are filtered by a fixed four-register pipeline.
package trap_pkg;
    // Register stages from input port to output port.
    localparam int STAGES = 4;
    // Taps covered by one partial-sum table.
    localparam int GROUP  = 4;
endpackage

// File: rtl/trap_da_lut.sv
// Partial-sum table for one group of four taps at one bit position.
// Each address bit selects one coefficient, and the table returns the
// sum of the coefficients it selects. The coefficients are constants,
// so this reduces to a 16-entry lookup.
// Assumes: GCOEF holds four signed CW-bit coefficients, tap 0 in the low bits.
module trap_da_lut #(
    parameter int              CW    = 12,
    parameter logic [4*CW-1:0] GCOEF = '0
) (
    input  logic [3:0]         addr,
    output logic signed [CW+1:0] psum
);
    // Add together the coefficients whose address bits are set.
    always_comb begin
        psum = '0;
        for (int j = 0; j < 4; j++) begin
            if (addr[j]) begin
                psum = psum + {{2{GCOEF[j*CW+CW-1]}}, GCOEF[j*CW +: CW]};
            end
        end
    end
endmodule

// File: rtl/trap_tap_line.sv
// Per-lane sample history. A sample moves in only when it is valid;
// tap 0 holds the newest sample. A delayed copy of the valid flag
// marks the clock in which the history changed.
// Assumes: synchronous active-low reset clears the whole history.
module trap_tap_line #(
    parameter int DW    = 14,
    parameter int NTAPS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DW-1:0]       in_data,
    output logic [NTAPS*DW-1:0] taps,
    output logic                tap_valid
);
    // Shift the history on each accepted sample; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps      <= '0;
            tap_valid <= 1'b0;
        end else begin
            tap_valid <= in_valid;
            if (in_valid) begin
                taps <= {taps[(NTAPS-1)*DW-1:0], in_data};
            end
        end
    end

    // R7: an accepted sample lands in tap 0 on the next clock
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taps[DW-1:0] == $past(in_data)));

    // R7: without a valid input the history stays put
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(taps));
endmodule

// File: rtl/trap_da_core.sv
// Distributed-arithmetic filter for one lane, with no multipliers.
// Stage 1: one table per (group, bit) is registered. Stage 2: the bit
// partials are weighted and summed per group, with the sign bit
// subtracted. Stage 3: the group sums are added into the output.
// Assumes: NTAPS is a multiple of four; samples are two's complement.
module trap_da_core #(
    parameter int                 DW    = 14,
    parameter int                 CW    = 12,
    parameter int                 NTAPS = 8,
    parameter int                 OW    = DW + CW + $clog2(NTAPS),
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTAPS*DW-1:0]  taps,
    input  logic                 tap_valid,
    output logic signed [OW-1:0] y,
    output logic                 y_valid
);
    localparam int NG  = NTAPS / trap_pkg::GROUP;
    localparam int PSW = CW + 2;

    logic signed [PSW-1:0] ps_d [NG][DW];
    logic signed [PSW-1:0] ps_q [NG][DW];
    logic signed [OW-1:0]  gs_d [NG];
    logic signed [OW-1:0]  gs_q [NG];
    logic                  v1, v2;

    // One partial-sum table per group and bit position.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar b = 0; b < DW; b++) begin : g_bit
            trap_da_lut #(
                .CW    (CW),
                .GCOEF (COEFS[g*4*CW +: 4*CW])
            ) u_lut (
                .addr ({taps[(4*g+3)*DW+b], taps[(4*g+2)*DW+b],
                        taps[(4*g+1)*DW+b], taps[(4*g)*DW+b]}),
                .psum (ps_d[g][b])
            );
        end
    end

    // Weight each bit partial by 2^b; the sign bit counts negative.
    always_comb begin
        for (int g = 0; g < NG; g++) begin
            logic signed [OW-1:0] acc;
            logic signed [OW-1:0] term;
            acc = '0;
            for (int b = 0; b < DW; b++) begin
                term = {{(OW-PSW){ps_q[g][b][PSW-1]}}, ps_q[g][b]} <<< b;
                if (b == DW - 1) acc = acc - term;
                else             acc = acc + term;
            end
            gs_d[g] = acc;
        end
    end

    // Pipeline registers: partial sums, group sums, output and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                for (int b = 0; b < DW; b++) ps_q[g][b] <= '0;
                gs_q[g] <= '0;
            end
            y       <= '0;
            v1      <= 1'b0;
            v2      <= 1'b0;
            y_valid <= 1'b0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                for (int b = 0; b < DW; b++) ps_q[g][b] <= ps_d[g][b];
                gs_q[g] <= gs_d[g];
            end
            y       <= sum_groups(gs_q);
            v1      <= tap_valid;
            v2      <= v1;
            y_valid <= v2;
        end
    end

    // Adds up the per-group sums.
    function automatic logic signed [OW-1:0] sum_groups(input logic signed [OW-1:0] s [NG]);
        logic signed [OW-1:0] t;
        t = '0;
        for (int g = 0; g < NG; g++) t = t + s[g];
        return t;
    endfunction

    // Assertion support: any registered partial sum nonzero.
    logic ps_nz;
    always_comb begin
        ps_nz = 1'b0;
        for (int g = 0; g < NG; g++)
            for (int b = 0; b < DW; b++)
                ps_nz = ps_nz | (ps_q[g][b] != '0);
    end

    // R3: an all-zero history gives all-zero partial sums on the next clock
    p_zero_hist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (taps == '0) |=> !ps_nz);
endmodule

// File: rtl/trap_shaper_top.sv
// Multi-lane trapezoidal pulse shaper. Each lane has its own history
// and filter, and all lanes share one coefficient set. Output is full
// precision, STAGES clocks behind the input.
// Assumes: COEFS already contains the deconvolution convolved with the
// trapezoid of rise time RISE, and RISE <= NTAPS/2.
module trap_shaper_top #(
    parameter int                  NCH   = 4,
    parameter int                  DW    = 14,
    parameter int                  CW    = 12,
    parameter int                  NTAPS = 8,
    parameter int                  RISE  = 1,
    parameter logic [NTAPS*CW-1:0] COEFS = {12'hED4, 12'h050, 12'h0A0, 12'h0C8,
                                            12'h0C8, 12'h0C8, 12'h078, 12'h028},
    localparam int                 OW    = DW + CW + $clog2(NTAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      in_valid,
    input  logic [NCH*DW-1:0]   in_data,
    output logic [NCH-1:0]      out_valid,
    output logic [NCH*OW-1:0]   out_data
);
    // Reject parameter sets the filter structure cannot hold.
    if (2 * RISE > NTAPS) begin : g_bad_rise
        $error("rise time exceeds half the filter length");
    end
    if (NTAPS % trap_pkg::GROUP != 0) begin : g_bad_taps
        $error("filter length must be a multiple of four");
    end

    // One history and one filter per lane.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [NTAPS*DW-1:0] taps;
        logic                tap_valid;
        logic signed [OW-1:0] y;

        trap_tap_line #(.DW(DW), .NTAPS(NTAPS)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[c]),
            .in_data   (in_data[c*DW +: DW]),
            .taps      (taps),
            .tap_valid (tap_valid)
        );

        trap_da_core #(
            .DW(DW), .CW(CW), .NTAPS(NTAPS), .OW(OW), .COEFS(COEFS)
        ) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .taps      (taps),
            .tap_valid (tap_valid),
            .y         (y),
            .y_valid   (out_valid[c])
        );

        assign out_data[c*OW +: OW] = y;
    end

    // Assertion support: clocks since reset, saturating at the latency.
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_rst <= '0;
        else if (since_rst != 3'(trap_pkg::STAGES)) since_rst <= since_rst + 3'd1;
    end

    // R1: nothing is valid until the pipeline has refilled
    p_quiet_refill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 3'(trap_pkg::STAGES)) |-> (out_valid == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2: each lane's valid is its input valid four clocks later
        p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 3'(trap_pkg::STAGES)) |-> (out_valid[c] == $past(in_valid[c], 4)));
    end
endmodule

// File: tb/sim_trap_shaper_top.sv
// Scoreboard bench: the driver computes the direct-form convolution and
// queues expected outputs; the monitor pops and compares valid outputs.
module sim_trap_shaper_top;
    localparam int CLK_PERIOD = 8;
    localparam int NCH   = 4;
    localparam int DW    = 14;
    localparam int CW    = 12;
    localparam int NTAPS = 8;
    localparam int OW    = DW + CW + $clog2(NTAPS);
    localparam logic [NTAPS*CW-1:0] COEFS = {12'hED4, 12'h050, 12'h0A0, 12'h0C8,
                                             12'h0C8, 12'h0C8, 12'h078, 12'h028};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH-1:0]      in_valid = '0;
    logic [NCH*DW-1:0]   in_data = '0;
    logic [NCH-1:0]      out_valid;
    logic [NCH*OW-1:0]   out_data;

    trap_shaper_top #(
        .NCH(NCH), .DW(DW), .CW(CW), .NTAPS(NTAPS), .RISE(1), .COEFS(COEFS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    int     n_checks = 0;
    int     n_fail   = 0;
    longint hist [NCH][NTAPS];
    longint exp_q [NCH][$];
    string  tag_q [NCH][$];
    logic [3:0] vh [NCH];

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic longint coef(input int k);
        return longint'($signed(COEFS[k*CW +: CW]));
    endfunction

    // Driver: apply one clock of input and queue the expected results.
    task automatic drive(input logic [NCH-1:0] v, input logic [NCH*DW-1:0] d, input string tag);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        for (int c = 0; c < NCH; c++) begin
            if (v[c]) begin
                longint acc;
                for (int k = NTAPS-1; k > 0; k--) hist[c][k] = hist[c][k-1];
                hist[c][0] = longint'($signed(d[c*DW +: DW]));
                acc = 0;
                for (int k = 0; k < NTAPS; k++) acc += coef(k) * hist[c][k];
                exp_q[c].push_back(acc);
                tag_q[c].push_back(tag);
            end
        end
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NTAPS; k++) hist[c][k] = 0;
            exp_q[c].delete();
            tag_q[c].delete();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = '0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        clear_model();
        rst_n = 1'b1;
    endtask

    function automatic logic [NCH*DW-1:0] rand_lanes();
        logic [NCH*DW-1:0] r;
        for (int c = 0; c < NCH; c++) r[c*DW +: DW] = DW'($urandom);
        return r;
    endfunction

    // Bench copy of the input valid history for the latency check.
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) vh[c] <= '0;
            else        vh[c] <= {vh[c][2:0], in_valid[c]};
        end
    end

    // Monitor: compare valid flags and pop expected data.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                check(out_valid[c] == vh[c][3], "R2 valid latency",
                      longint'(out_valid[c]), longint'(vh[c][3]));
                if (out_valid[c]) begin
                    longint got;
                    got = longint'($signed(out_data[c*OW +: OW]));
                    if (exp_q[c].size() == 0) begin
                        check(1'b0, "R2 unexpected output", got, 0);
                    end else begin
                        longint e;
                        string  t;
                        e = exp_q[c].pop_front();
                        t = tag_q[c].pop_front();
                        check(got == e, t, got, e);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [NCH*DW-1:0] d;
        clear_model();
        do_reset();
        // R1: reset state at the ports
        @(negedge clk);
        check(out_valid == '0, "R1 valid after reset", longint'(out_valid), 0);
        for (int c = 0; c < NCH; c++)
            check(out_data[c*OW +: OW] == '0, "R1 data after reset",
                  longint'($signed(out_data[c*OW +: OW])), 0);

        // R4 impulse of 1 on lane 0; R5 other lanes fed zeros stay zero
        d = '0; d[0 +: DW] = DW'(1);
        drive('1, d, "R4");
        for (int i = 0; i < NTAPS + 2; i++) drive('1, '0, "R4");
        // R4 impulse of -3 on lane 2 alone; R5 others still valid with zeros
        d = '0; d[2*DW +: DW] = DW'(-3);
        drive('1, d, "R5");
        for (int i = 0; i < NTAPS + 2; i++) drive('1, '0, "R5");

        // R3 random samples, all lanes every clock
        for (int i = 0; i < 300; i++) drive('1, rand_lanes(), "R3");

        // R7 random samples with random gaps per lane
        for (int i = 0; i < 200; i++) drive(NCH'($urandom), rand_lanes(), "R7");

        // R6 full-scale extremes
        for (int i = 0; i < 60; i++) begin
            for (int c = 0; c < NCH; c++)
                d[c*DW +: DW] = ($urandom % 2) ? {1'b0, {(DW-1){1'b1}}} : {1'b1, {(DW-1){1'b0}}};
            drive('1, d, "R6");
        end

        // R8 reset in mid-stream clears history
        for (int i = 0; i < 20; i++) drive('1, rand_lanes(), "R3");
        do_reset();
        for (int i = 0; i < 30; i++) drive('1, rand_lanes(), "R8");

        // Flush and confirm every accepted sample produced an output
        for (int i = 0; i < 8; i++) drive('0, '0, "R2");
        for (int c = 0; c < NCH; c++)
            check(exp_q[c].size() == 0, "R2 outputs outstanding",
                  longint'(exp_q[c].size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule